// File: doc/BRIEF.md
# Single-Line Snooping Coherence Controller

This block keeps one cache line coherent on behalf of one processor. Two engines share a single state-and-data register. The processor engine serves blocking loads and stores. When the line state cannot satisfy a request, it sends a request to a central memory controller. The snoop engine answers read and invalidate queries that the memory controller sends. Neither engine touches the shared register until it owns an internal line lock. The lock is taken with a single-cycle test-and-set and released when that engine's transaction completes.

The line state takes one of four values, encoded on `line_state` as Invalid=0, Shared=1, Exclusive=2 and Modified=3. The processor engine keeps the lock from the moment it accepts a request until the processor takes the response. The two engines have separate channels and separate state machines, so a pending memory reply never blocks the snoop engine's logic. A snoop that arrives during a processor transaction is only held off by back-pressure. Every data-carrying channel uses valid/ready. A valid, once raised, stays high with its payload unchanged until the cycle in which ready is high, and the transfer happens in that cycle. Memory request kinds are 0 for a data fetch, 1 for a store permission only, and 2 for a data fetch combined with store permission.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset, `line_state` is Invalid (0), and `cpu_rsp_valid`, `mreq_valid` and `sack_valid` are low.
- R2: A load in Invalid issues a memory request of kind 0 and returns no response before the memory reply. The reply fills the line in Exclusive (2) if `mrsp_excl` is 1 and in Shared (1) otherwise, and the processor receives `mrsp_data`.
- R3: A load in Shared, Exclusive or Modified returns the line data without any memory request.
- R4: A store in Modified writes the store data with no memory request; line data never changes except by such a store or by a memory reply.
- R5: A store in Shared or Exclusive issues a request of kind 1. On the reply the line becomes Modified (3) holding the store data; the line never enters Modified without a memory reply.
- R6: A store in Invalid issues a request of kind 2, and on the reply the line becomes Modified holding the store data.
- R7: A snoop invalidate (`snp_inval`=1) leaves the line Invalid. It answers with `sack_has_data`=1 and the line data only when the line was Modified.
- R8: A snoop read (`snp_inval`=0) moves Modified or Exclusive to Shared and leaves Shared and Invalid unchanged. It supplies data only when the line was Modified.
- R9: While a processor transaction is open (request accepted, response not yet taken), `snp_ready` stays low and only one engine ever writes the line.
- R10: When the lock is free and both engines request it in the same cycle, the snoop engine wins.
- R11: `cpu_rsp_valid`, `mreq_valid` and `sack_valid` hold, with stable payload, until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Processor response valid |
| cpu_rsp_ready | input | 1 | Processor takes response |
| cpu_rsp_rdata | output | DATA_W | Load data (store data for stores) |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory controller accepts request |
| mreq_kind | output | 2 | 0 fetch, 1 permission, 2 fetch with permission |
| mrsp_valid | input | 1 | Memory reply valid |
| mrsp_ready | output | 1 | Reply accepted |
| mrsp_excl | input | 1 | Fetch grants exclusive ownership |
| mrsp_data | input | DATA_W | Fetched line data |
| snp_valid | input | 1 | Snoop query valid |
| snp_ready | output | 1 | Snoop accepted |
| snp_inval | input | 1 | 1 = invalidate, 0 = read |
| sack_valid | output | 1 | Snoop answer valid |
| sack_ready | input | 1 | Memory controller takes answer |
| sack_has_data | output | 1 | Answer carries dirty data |
| sack_data | output | DATA_W | Dirty line data |
| line_state | output | 2 | Current coherence state |

## Verification
Loads, stores and both snoop kinds are issued in a seeded random order against a bench model of the line. The model is checked for every transition out of each of the four states. Each memory reply uses a random delay and a random exclusive flag, and the results show apart fills to Shared and fills to Exclusive, as well as which request kind each state produces. Random response and answer back-pressure tests that payloads stay stable. Two directed cases cover the remaining rules. In the first, a snoop arrives while a fetch is outstanding; it must stall and then see the filled state. In the second, a processor request and an invalidate arrive together on a Modified line, and the winner shows in the following fetch.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  localparam int KIND_W = 2;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_e;
  typedef enum logic [KIND_W-1:0] {MK_DATA = 2'd0, MK_PERM = 2'd1, MK_DATA_PERM = 2'd2} mreq_kind_e;
  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_PROC = 2'd1, OWN_SNP = 2'd2} owner_e;
endpackage

// File: rtl/coh_line_lock.sv
`timescale 1ns/1ps
module coh_line_lock
  import coh_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   proc_req,
  input  logic   proc_rel,
  input  logic   snp_req,
  input  logic   snp_rel,
  output owner_e owner
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else begin
      unique case (owner)
        OWN_NONE: if (snp_req) owner <= OWN_SNP;
                  else if (proc_req) owner <= OWN_PROC;
        OWN_PROC: if (proc_rel) owner <= OWN_NONE;
        OWN_SNP:  if (snp_rel) owner <= OWN_NONE;
        default:  owner <= OWN_NONE;
      endcase
    end
  end

  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && snp_req && proc_req) |=> owner == OWN_SNP); // R10
  AST_PROC_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_PROC && !proc_rel) |=> owner == OWN_PROC); // R9
endmodule

// File: rtl/coh_proc_eng.sv
`timescale 1ns/1ps
module coh_proc_eng
  import coh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [KIND_W-1:0] mreq_kind,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic              mrsp_excl,
  input  logic [DATA_W-1:0] mrsp_data,
  input  logic              own,
  output logic              lock_req,
  output logic              lock_rel,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              we,
  output line_st_e          st_nxt,
  output logic [DATA_W-1:0] data_nxt
);
  typedef enum logic [1:0] {P_IDLE, P_MREQ, P_MWAIT, P_RSP} pst_e;
  pst_e              pst;
  logic              is_wr;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  mreq_kind_e        kind_q;
  logic              accept, fill;

  assign cpu_req_ready = (pst == P_IDLE) && own;
  assign lock_req      = (pst == P_IDLE) && cpu_req_valid;
  assign mreq_valid    = (pst == P_MREQ);
  assign mreq_kind     = kind_q;
  assign mrsp_ready    = (pst == P_MWAIT);
  assign cpu_rsp_valid = (pst == P_RSP);
  assign cpu_rsp_rdata = rd_q;
  assign lock_rel      = (pst == P_RSP) && cpu_rsp_ready;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign fill          = mrsp_valid && mrsp_ready;

  always_comb begin
    we       = 1'b0;
    st_nxt   = line_st;
    data_nxt = line_data;
    if (accept && cpu_req_write && line_st == LS_M) begin
      we       = 1'b1;
      data_nxt = cpu_req_wdata;
    end else if (fill) begin
      we = 1'b1;
      if (is_wr) begin
        st_nxt   = LS_M;
        data_nxt = wd_q;
      end else begin
        st_nxt   = mrsp_excl ? LS_E : LS_S;
        data_nxt = mrsp_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst    <= P_IDLE;
      is_wr  <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      kind_q <= MK_DATA;
    end else begin
      unique case (pst)
        P_IDLE: if (accept) begin
          is_wr <= cpu_req_write;
          wd_q  <= cpu_req_wdata;
          if (cpu_req_write) begin
            if (line_st == LS_M) begin
              rd_q <= cpu_req_wdata;
              pst  <= P_RSP;
            end else begin
              kind_q <= (line_st == LS_I) ? MK_DATA_PERM : MK_PERM;
              pst    <= P_MREQ;
            end
          end else if (line_st != LS_I) begin
            rd_q <= line_data;
            pst  <= P_RSP;
          end else begin
            kind_q <= MK_DATA;
            pst    <= P_MREQ;
          end
        end
        P_MREQ:  if (mreq_ready) pst <= P_MWAIT;
        P_MWAIT: if (fill) begin
          rd_q <= is_wr ? wd_q : mrsp_data;
          pst  <= P_RSP;
        end
        P_RSP:   if (cpu_rsp_ready) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  AST_RSP_LINE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> line_st != LS_I); // R2
  AST_LOAD_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_write && line_st == LS_I) |=> (mreq_valid && mreq_kind == MK_DATA)); // R2
  AST_STORE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_req_write && line_st != LS_M) |=> mreq_valid); // R5
  AST_OPEN_TXN_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (pst != P_IDLE) |-> own); // R9
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_kind))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata))); // R11
endmodule

// File: rtl/coh_snoop_eng.sv
`timescale 1ns/1ps
module coh_snoop_eng
  import coh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_inval,
  output logic              sack_valid,
  input  logic              sack_ready,
  output logic              sack_has_data,
  output logic [DATA_W-1:0] sack_data,
  input  logic              own,
  output logic              lock_req,
  output logic              lock_rel,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              we,
  output line_st_e          st_nxt
);
  logic              busy;
  logic              has_q;
  logic [DATA_W-1:0] dat_q;

  assign snp_ready     = !busy && own;
  assign lock_req      = !busy && snp_valid;
  assign we            = snp_valid && snp_ready;
  assign sack_valid    = busy;
  assign sack_has_data = has_q;
  assign sack_data     = dat_q;
  assign lock_rel      = busy && sack_ready;

  always_comb begin
    if (snp_inval) st_nxt = LS_I;
    else if (line_st == LS_M || line_st == LS_E) st_nxt = LS_S;
    else st_nxt = line_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      has_q <= 1'b0;
      dat_q <= '0;
    end else if (!busy) begin
      if (we) begin
        busy  <= 1'b1;
        has_q <= (line_st == LS_M);
        dat_q <= line_data;
      end
    end else if (sack_ready) begin
      busy <= 1'b0;
    end
  end

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && snp_inval) |=> line_st == LS_I); // R7
  AST_READ_DROPS_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !snp_inval) |=> (line_st == LS_I || line_st == LS_S)); // R8
  AST_SACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sack_valid && !sack_ready) |=> (sack_valid && $stable(sack_has_data) && $stable(sack_data))); // R11
endmodule

// File: rtl/coh_line_ctrl.sv
`timescale 1ns/1ps
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [1:0]        mreq_kind,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic              mrsp_excl,
  input  logic [DATA_W-1:0] mrsp_data,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_inval,
  output logic              sack_valid,
  input  logic              sack_ready,
  output logic              sack_has_data,
  output logic [DATA_W-1:0] sack_data,
  output logic [1:0]        line_state
);
  owner_e            owner;
  line_st_e          st_q, p_st, s_st;
  logic [DATA_W-1:0] data_q, p_data;
  logic              p_we, s_we, p_lreq, p_lrel, s_lreq, s_lrel;

  coh_line_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .proc_req(p_lreq), .proc_rel(p_lrel),
    .snp_req(s_lreq), .snp_rel(s_lrel),
    .owner(owner)
  );

  coh_proc_eng #(.DATA_W(DATA_W)) u_proc (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_kind(mreq_kind),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready),
    .mrsp_excl(mrsp_excl), .mrsp_data(mrsp_data),
    .own(owner == OWN_PROC), .lock_req(p_lreq), .lock_rel(p_lrel),
    .line_st(st_q), .line_data(data_q),
    .we(p_we), .st_nxt(p_st), .data_nxt(p_data)
  );

  coh_snoop_eng #(.DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_inval(snp_inval),
    .sack_valid(sack_valid), .sack_ready(sack_ready),
    .sack_has_data(sack_has_data), .sack_data(sack_data),
    .own(owner == OWN_SNP), .lock_req(s_lreq), .lock_rel(s_lrel),
    .line_st(st_q), .line_data(data_q),
    .we(s_we), .st_nxt(s_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_I;
      data_q <= '0;
    end else if (s_we) begin
      st_q <= s_st;
    end else if (p_we) begin
      st_q   <= p_st;
      data_q <= p_data;
    end
  end

  assign line_state = st_q;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_we && s_we)); // R9
  AST_WRITER_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we |-> owner == OWN_PROC) and (s_we |-> owner == OWN_SNP)); // R9
  AST_M_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_M && $past(st_q) != LS_M) |-> $past(mrsp_valid && mrsp_ready)); // R5
  AST_DATA_WRITE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> ($past(st_q) == LS_M || $past(mrsp_valid && mrsp_ready))); // R4
endmodule

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/1ps
module test_coh_line_ctrl;
  localparam int DW = 32;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_ready, cpu_req_write = 0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_rsp_valid, cpu_rsp_ready = 0;
  logic [DW-1:0] cpu_rsp_rdata;
  logic mreq_valid, mreq_ready = 0;
  logic [1:0] mreq_kind;
  logic mrsp_valid = 0, mrsp_ready, mrsp_excl = 0;
  logic [DW-1:0] mrsp_data = '0;
  logic snp_valid = 0, snp_ready, snp_inval = 0;
  logic sack_valid, sack_ready = 0, sack_has_data;
  logic [DW-1:0] sack_data;
  logic [1:0] line_state;

  int total = 0, bad = 0;
  logic [1:0] exp_st = SI;
  logic [DW-1:0] exp_data = '0;

  always #2 clk = ~clk;

  coh_line_ctrl #(.DATA_W(DW)) i_coh_line_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] snoop_next(input logic [1:0] st, input bit inval);
    if (inval) return SI;
    if (st == SM || st == SE) return SS;
    return st;
  endfunction

  function automatic logic [1:0] store_kind(input logic [1:0] st);
    return (st == SI) ? 2'd2 : 2'd1;
  endfunction

  task automatic cpu_send(input bit wr, input logic [DW-1:0] wd);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic mem_serve(input logic [1:0] kind, input int dly, input bit excl, input logic [DW-1:0] md);
    while (!mreq_valid) begin
      chk(!cpu_rsp_valid, "R2 response before memory reply", cpu_rsp_valid, 0);
      @(negedge clk);
    end
    chk(mreq_kind == kind, "R2/R5/R6 request kind", mreq_kind, kind);
    mreq_ready = 1; @(negedge clk); mreq_ready = 0;
    repeat (dly) begin
      chk(!cpu_rsp_valid, "R2 blocking until reply", cpu_rsp_valid, 0);
      @(negedge clk);
    end
    mrsp_valid = 1; mrsp_excl = excl; mrsp_data = md;
    while (!mrsp_ready) @(negedge clk);
    @(negedge clk);
    mrsp_valid = 0;
  endtask

  task automatic cpu_take(input bit hit, input int hold, output logic [DW-1:0] rd);
    logic [DW-1:0] first;
    while (!cpu_rsp_valid) begin
      if (hit) chk(!mreq_valid, "R3/R4 hit raised memory request", mreq_valid, 0);
      @(negedge clk);
    end
    first = cpu_rsp_rdata;
    repeat (hold) begin
      @(negedge clk);
      chk(cpu_rsp_valid && cpu_rsp_rdata == first, "R11 response held", cpu_rsp_rdata, first);
    end
    rd = cpu_rsp_rdata;
    cpu_rsp_ready = 1; @(negedge clk); cpu_rsp_ready = 0;
  endtask

  task automatic snp_send(input bit inval);
    snp_valid = 1; snp_inval = inval;
    while (!snp_ready) @(negedge clk);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic snp_take(input int hold, output bit hd, output logic [DW-1:0] dd);
    logic hd0; logic [DW-1:0] d0;
    while (!sack_valid) @(negedge clk);
    hd0 = sack_has_data; d0 = sack_data;
    repeat (hold) begin
      @(negedge clk);
      chk(sack_valid && sack_has_data == hd0 && sack_data == d0, "R11 snoop answer held", sack_data, d0);
    end
    hd = sack_has_data; dd = sack_data;
    sack_ready = 1; @(negedge clk); sack_ready = 0;
  endtask

  task automatic op_load(input int dly, input bit excl, input logic [DW-1:0] md, input int hold);
    logic [DW-1:0] rd;
    bit miss = (exp_st == SI);
    cpu_send(0, '0);
    if (miss) begin
      mem_serve(2'd0, dly, excl, md);
      exp_st = excl ? SE : SS;
      exp_data = md;
    end
    cpu_take(!miss, hold, rd);
    chk(rd == exp_data, miss ? "R2 load fill data" : "R3 load hit data", rd, exp_data);
    chk(line_state == exp_st, miss ? "R2 fill state" : "R3 hit state kept", line_state, exp_st);
  endtask

  task automatic op_store(input logic [DW-1:0] wd, input int dly, input int hold);
    logic [DW-1:0] rd;
    bit hit = (exp_st == SM);
    logic [1:0] k = store_kind(exp_st);
    cpu_send(1, wd);
    if (!hit) mem_serve(k, dly, 1'b0, ~wd);
    exp_st = SM; exp_data = wd;
    cpu_take(hit, hold, rd);
    chk(line_state == SM, hit ? "R4 store hit state" : (k == 2'd2 ? "R6 store grant state" : "R5 store grant state"), line_state, SM);
  endtask

  task automatic op_snoop(input bit inval, input int hold);
    bit hd; logic [DW-1:0] dd;
    bit want = (exp_st == SM);
    snp_send(inval);
    snp_take(hold, hd, dd);
    chk(hd == want, inval ? "R7 invalidate data flag" : "R8 read data flag", hd, want);
    if (want) chk(dd == exp_data, inval ? "R7 invalidate data" : "R8 read data", dd, exp_data);
    exp_st = snoop_next(exp_st, inval);
    chk(line_state == exp_st, inval ? "R7 state after invalidate" : "R8 state after read", line_state, exp_st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit hd; logic [DW-1:0] dd, rd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(line_state == SI, "R1 reset state", line_state, SI);
    chk(!cpu_rsp_valid && !mreq_valid && !sack_valid, "R1 reset valids", {cpu_rsp_valid, mreq_valid, sack_valid}, 0);

    op_load(2, 0, 32'h1111_0001, 1);   // R2 fill Shared
    op_load(0, 0, '0, 0);              // R3 hit
    op_snoop(0, 0);                    // R8 Shared read
    op_store(32'h2222_0002, 1, 0);     // R5 permission from Shared
    op_store(32'h3333_0003, 0, 2);     // R4 hit in Modified
    op_load(0, 0, '0, 0);              // R3 hit in Modified
    op_snoop(0, 1);                    // R8 Modified supplies data
    op_snoop(1, 0);                    // R7 Shared invalidate
    op_snoop(1, 0);                    // R7 Invalid stays
    op_snoop(0, 0);                    // R8 Invalid stays
    op_load(1, 1, 32'h4444_0004, 0);   // R2 fill Exclusive
    op_snoop(0, 0);                    // R8 Exclusive -> Shared
    op_snoop(1, 0);
    op_load(0, 1, 32'h5555_0005, 0);
    op_store(32'h6666_0006, 0, 0);     // R5 permission from Exclusive
    op_snoop(1, 1);                    // R7 Modified invalidate
    op_store(32'h7777_0007, 2, 0);     // R6 fetch with permission

    // R9: snoop stalls while a fetch is outstanding
    op_snoop(1, 0);
    fork
      begin cpu_send(0, '0); mem_serve(2'd0, 8, 1'b0, 32'hA5A5_0009); end
      begin
        repeat (3) @(negedge clk);
        snp_valid = 1; snp_inval = 0;
        repeat (6) begin
          chk(!snp_ready, "R9 snoop stalled during open transaction", snp_ready, 0);
          @(negedge clk);
        end
      end
    join
    chk(!snp_ready, "R9 snoop stalled until response taken", snp_ready, 0);
    cpu_take(0, 1, rd);
    chk(rd == 32'hA5A5_0009, "R9 returned data not disturbed", rd, 32'hA5A5_0009);
    exp_st = SS; exp_data = 32'hA5A5_0009;
    op_snoop(0, 0);

    // R10: simultaneous request, snoop wins
    op_store(32'hBEEF_0010, 0, 0);
    fork
      begin snp_send(1); snp_take(0, hd, dd); end
      begin cpu_send(0, '0); end
    join
    chk(hd == 1'b1 && dd == 32'hBEEF_0010, "R10 snoop served first on Modified", dd, 32'hBEEF_0010);
    mem_serve(2'd0, 0, 1'b1, 32'hC0DE_0011);
    cpu_take(0, 0, rd);
    chk(rd == 32'hC0DE_0011, "R10 load saw invalidated line", rd, 32'hC0DE_0011);
    exp_st = SE; exp_data = 32'hC0DE_0011;
    chk(line_state == SE, "R10 state after fill", line_state, SE);

    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      int dly = $urandom_range(0, 3);
      int hold = $urandom_range(0, 2);
      case (op)
        0: op_load(dly, bit'($urandom_range(0, 1)), $urandom, hold);
        1: op_store($urandom, dly, hold);
        2: op_snoop(0, hold);
        default: op_snoop(1, hold);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule